// File: doc/BRIEF.md
# Network Controller Command Register with Reset Sequencer

This block is the 8-bit command register of a network controller. A host write with the reset bit set starts a soft reset that lasts a fixed number of cycles. For that whole time the reset bit reads back as 1. The block halts both engines and holds the receive ring pointers and the transmit descriptor index at their initial values. When the count runs out, the reset bit clears itself. The station address, multicast filter and configuration registers are held elsewhere, and this block has no path to them.

The transmit-enable and receive-enable bits do not store what was written. Writing 1 to one of them asks the matching engine to start. The block issues a one-cycle start pulse only when that engine reports idle and no reset is pending. On a read, each enable bit shows the live activity line of its engine. Bit 0 shows that the receive ring holds no frame. It is derived by comparing the receive write pointer with the host read pointer, and it is forced to 1 while a reset runs.

Top module: `netctl_cmd_reg`

## Requirements
- R1: After the synchronous reset `rst`, with both engines idle, `rd_data_o` reads 0x01. All pointers and the descriptor index are 0. No start pulse and no halt is asserted.
- R2: Bits 7, 6, 5 and 1 of `rd_data_o` always read 0. Writing 1 to those bits changes no output.
- R3: A write with bit 4 set while no reset runs makes bit 4 read 1 from the next cycle on, for exactly RST_CYC cycles (default 8). After that, bit 4 returns to 0 by itself. A bit-4 write during a running reset neither restarts it nor lengthens it.
- R4: While bit 4 reads 1, `tx_halt_o` and `rx_halt_o` are high. The receive write pointer, the host read pointer and the transmit descriptor index are 0. `rx_push_i`, `rx_pop_i` and `tx_done_i` have no effect. The write that starts the reset also clears them.
- R5: Bit 0 reads 1 during the whole reset, whatever the pointers are.
- R6: A write with bit 3 set, bit 4 clear and no reset running raises `rx_start_o` for one cycle on the next cycle, but only if `rx_active_i` was low at the write. Otherwise no pulse is issued.
- R7: A write with bit 2 set follows the same rule for `tx_start_o`, gated by `tx_active_i`.
- R8: Bit 3 reads the current `rx_active_i`, and bit 2 reads the current `tx_active_i`, in the same cycle.
- R9: Enable writes are ignored while a reset runs, and also when bit 4 is set in the same write.
- R10: Outside a reset, bit 0 reads 1 exactly when the host read pointer equals the receive write pointer. `rx_push_i` advances the write pointer by one. `rx_pop_i` advances the read pointer by one only when the ring is not empty. Both pointers wrap modulo 2^PTR_W.
- R11: `tx_done_i` advances `tx_desc_o` by one, wrapping from NUM_DESC-1 to 0 (default 4 descriptors).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe for the command register |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Command register read value |
| tx_active_i | input | 1 | Transmit engine is active |
| rx_active_i | input | 1 | Receive engine is active |
| tx_start_o | output | 1 | One-cycle request to start the transmit engine |
| rx_start_o | output | 1 | One-cycle request to start the receive engine |
| tx_halt_o | output | 1 | Transmit engine held disabled by soft reset |
| rx_halt_o | output | 1 | Receive engine held disabled by soft reset |
| rx_push_i | input | 1 | One received frame stored in the ring |
| rx_pop_i | input | 1 | Host has consumed one frame |
| tx_done_i | input | 1 | Current transmit descriptor finished |
| rx_wr_ptr_o | output | PTR_W | Receive ring write pointer |
| host_rd_ptr_o | output | PTR_W | Host read pointer |
| tx_desc_o | output | $clog2(NUM_DESC) | Current transmit descriptor index |

## Verification
The assertions assume the ring is never filled to 2^PTR_W outstanding frames. If it were, the full ring would alias with the empty ring and the empty flag would be wrong. The stimulus keeps at most a few frames queued. The assertions also assume the engine activity lines are stable around each clock edge. The bench changes those lines, like every other input, only just after a rising edge. The start-pulse properties take as given that an engine reports itself active only after a start pulse or from an outside cause. The bench drives the activity lines freely, so both the idle case and the busy case of every enable write are exercised.

// File: rtl/netctl_cmd_pkg.sv
package netctl_cmd_pkg;
  localparam int CMD_W      = 8;
  localparam int BIT_RST    = 4;
  localparam int BIT_RXEN   = 3;
  localparam int BIT_TXEN   = 2;
  localparam int BIT_EMPTY  = 0;
  localparam int ENG_TX     = 0;
  localparam int ENG_RX     = 1;
  localparam int NUM_ENG    = 2;

  function automatic int eng_bit(input int idx);
    return (idx == ENG_TX) ? BIT_TXEN : BIT_RXEN;
  endfunction
endpackage

// File: rtl/cmd_rst_seq.sv
module cmd_rst_seq #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic busy_o,
  output logic clr_o
);
  localparam int CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             launch;

  assign launch = kick_i && !busy_o;
  assign clr_o  = launch || busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (busy_o) begin
      if (cnt == '0) busy_o <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end else if (launch) begin
      busy_o <= 1'b1;
      cnt    <= CNT_INIT;
    end
  end

  // R3
  reset_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(cnt) == '0);
  // R3
  reset_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(kick_i));
endmodule

// File: rtl/cmd_eng_gate.sv
module cmd_eng_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic block_i,
  input  logic active_i,
  output logic start_o
);
  always_ff @(posedge clk) begin
    if (rst) start_o <= 1'b0;
    else     start_o <= req_i && !block_i && !active_i;
  end

  // R6 R7 R9
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(req_i) && !$past(block_i) && !$past(active_i));
endmodule

// File: rtl/cmd_ring_ptr.sv
module cmd_ring_ptr #(
  parameter int PTR_W    = 4,
  parameter int NUM_DESC = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic                        push_i,
  input  logic                        pop_i,
  input  logic                        done_i,
  output logic [PTR_W-1:0]            wr_ptr_o,
  output logic [PTR_W-1:0]            rd_ptr_o,
  output logic [$clog2(NUM_DESC)-1:0] desc_o,
  output logic                        empty_o
);
  localparam int DESC_W = $clog2(NUM_DESC);
  localparam logic [DESC_W-1:0] DESC_LAST = DESC_W'(NUM_DESC - 1);

  assign empty_o = (wr_ptr_o == rd_ptr_o);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      desc_o   <= '0;
    end else begin
      if (push_i)            wr_ptr_o <= wr_ptr_o + 1'b1;
      if (pop_i && !empty_o) rd_ptr_o <= rd_ptr_o + 1'b1;
      if (done_i)            desc_o   <= (desc_o == DESC_LAST) ? '0 : desc_o + 1'b1;
    end
  end

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> (wr_ptr_o == '0) && (rd_ptr_o == '0) && (desc_o == '0));
  // R10
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    $past(empty_o) && !$past(clr_i) |-> $stable(rd_ptr_o));
endmodule

// File: rtl/netctl_cmd_reg.sv
module netctl_cmd_reg
  import netctl_cmd_pkg::*;
#(
  parameter int RST_CYC  = 8,
  parameter int PTR_W    = 4,
  parameter int NUM_DESC = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic [7:0]                  wr_data_i,
  output logic [7:0]                  rd_data_o,
  input  logic                        tx_active_i,
  input  logic                        rx_active_i,
  output logic                        tx_start_o,
  output logic                        rx_start_o,
  output logic                        tx_halt_o,
  output logic                        rx_halt_o,
  input  logic                        rx_push_i,
  input  logic                        rx_pop_i,
  input  logic                        tx_done_i,
  output logic [PTR_W-1:0]            rx_wr_ptr_o,
  output logic [PTR_W-1:0]            host_rd_ptr_o,
  output logic [$clog2(NUM_DESC)-1:0] tx_desc_o
);
  logic               busy, clr, ring_empty, kick;
  logic [NUM_ENG-1:0] eng_active, eng_start;

  assign kick          = wr_en_i && wr_data_i[BIT_RST];
  assign eng_active[ENG_TX] = tx_active_i;
  assign eng_active[ENG_RX] = rx_active_i;

  cmd_rst_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst(rst), .kick_i(kick), .busy_o(busy), .clr_o(clr)
  );

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    cmd_eng_gate u_gate (
      .clk      (clk),
      .rst      (rst),
      .req_i    (wr_en_i && wr_data_i[eng_bit(g)]),
      .block_i  (busy || wr_data_i[BIT_RST]),
      .active_i (eng_active[g]),
      .start_o  (eng_start[g])
    );
  end

  cmd_ring_ptr #(.PTR_W(PTR_W), .NUM_DESC(NUM_DESC)) u_ring (
    .clk(clk), .rst(rst), .clr_i(clr),
    .push_i(rx_push_i), .pop_i(rx_pop_i), .done_i(tx_done_i),
    .wr_ptr_o(rx_wr_ptr_o), .rd_ptr_o(host_rd_ptr_o),
    .desc_o(tx_desc_o), .empty_o(ring_empty)
  );

  assign tx_start_o = eng_start[ENG_TX];
  assign rx_start_o = eng_start[ENG_RX];
  assign tx_halt_o  = busy;
  assign rx_halt_o  = busy;

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[BIT_RST]   = busy;
    rd_data_o[BIT_RXEN]  = rx_active_i;
    rd_data_o[BIT_TXEN]  = tx_active_i;
    rd_data_o[BIT_EMPTY] = busy || ring_empty;
  end

  // R4 R9
  halt_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_halt_o || rx_halt_o) && $past(tx_halt_o) |-> !tx_start_o && !rx_start_o);
  // R5
  empty_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    tx_halt_o |-> rd_data_o[BIT_EMPTY]);
endmodule

// File: tb/sim_netctl_cmd_reg.sv
module sim_netctl_cmd_reg;
  localparam int RST_CYC = 8, PTR_W = 4, NUM_DESC = 4;

  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [7:0] wr_data = 0;
  logic tx_act = 0, rx_act = 0, push = 0, pop = 0, done = 0;
  logic [7:0] rd;
  logic tx_st, rx_st, tx_h, rx_h;
  logic [PTR_W-1:0] wp, rp;
  logic [1:0] desc;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  netctl_cmd_reg #(.RST_CYC(RST_CYC), .PTR_W(PTR_W), .NUM_DESC(NUM_DESC)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd),
    .tx_active_i(tx_act), .rx_active_i(rx_act), .tx_start_o(tx_st), .rx_start_o(rx_st),
    .tx_halt_o(tx_h), .rx_halt_o(rx_h), .rx_push_i(push), .rx_pop_i(pop),
    .tx_done_i(done), .rx_wr_ptr_o(wp), .host_rd_ptr_o(rp), .tx_desc_o(desc));

  // reference model
  int m_busy = 0, m_wr = 0, m_rd = 0, m_desc = 0;
  bit m_txs = 0, m_rxs = 0;
  always @(posedge clk) begin
    bit launch, ok, clr;
    if (rst) begin
      m_busy = 0; m_wr = 0; m_rd = 0; m_desc = 0; m_txs = 0; m_rxs = 0;
    end else begin
      launch = wr_en && wr_data[4] && m_busy == 0;
      ok     = wr_en && m_busy == 0 && !wr_data[4];
      m_rxs  = ok && wr_data[3] && !rx_act;
      m_txs  = ok && wr_data[2] && !tx_act;
      clr    = launch || m_busy > 0;
      if (clr) begin m_wr = 0; m_rd = 0; m_desc = 0; end
      else begin
        if (pop && m_rd != m_wr) m_rd = (m_rd + 1) % (1 << PTR_W);
        if (push) m_wr = (m_wr + 1) % (1 << PTR_W);
        if (done) m_desc = (m_desc + 1) % NUM_DESC;
      end
      if (m_busy > 0) m_busy--; else if (launch) m_busy = RST_CYC;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    bit b;
    b = m_busy > 0;
    chk("R2 reserved bits", {rd[7:5], rd[1]}, 0);
    chk("R3 reset bit", rd[4], b);
    chk("R8 rx enable readback", rd[3], rx_act);
    chk("R8 tx enable readback", rd[2], tx_act);
    chk("R5/R10 empty bit", rd[0], b || m_wr == m_rd);
    chk("R4 halts", {tx_h, rx_h}, {b, b});
    chk("R6 rx start", rx_st, m_rxs);
    chk("R7 tx start", tx_st, m_txs);
    chk("R10 write pointer", wp, m_wr);
    chk("R10 read pointer", rp, m_rd);
    chk("R11 descriptor", desc, m_desc);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3); rst = 0; #3;
    // R1
    chk("R1 reset readback", rd, 8'h01);
    chk("R1 outputs", {tx_st, rx_st, tx_h, rx_h, wp, rp, desc}, 0);
    step();
    // R2 reserved bit writes
    wr(8'hE2); step();
    chk("R2 after reserved write", rd, 8'h01);
    // R10 ring
    push = 1; step(3); push = 0;
    pop = 1; step(2); pop = 0;
    chk("R10 not empty", rd[0], 0);
    pop = 1; step(3); pop = 0;
    chk("R10 empty pop ignored", rp, 3);
    // R11 wrap
    done = 1; step(5); done = 0;
    chk("R11 wrap", desc, 1);
    // R6 R7 idle and active engines
    wr(8'h08); #3; chk("R6 rx pulse", rx_st, 1); step();
    chk("R6 one cycle", rx_st, 0);
    rx_act = 1; wr(8'h08); #3; chk("R6 blocked when active", rx_st, 0); step();
    wr(8'h04); #3; chk("R7 tx pulse", tx_st, 1); step();
    tx_act = 1; wr(8'h0C); #3; chk("R7 blocked when active", tx_st, 0); step();
    rx_act = 0; tx_act = 0; step();
    // R3 R4 R5 reset with traffic
    push = 1; step(2); push = 0;
    wr(8'h10);
    push = 1; pop = 1; done = 1;
    step(3);
    wr(8'h1C); // R9: enable + re-kick during reset
    #3; chk("R9 no start during reset", {tx_st, rx_st}, 0);
    step(2);
    push = 0; pop = 0; done = 0;
    chk("R3 still resetting", rd[4], 1);
    step(3);
    chk("R3 reset done after RST_CYC", rd[4], 0);
    chk("R4 pointers clear", {wp, rp, desc}, 0);
    // R9 enable with reset in same write
    wr(8'h1C); #3; chk("R9 combined write", {tx_st, rx_st}, 0);
    step(RST_CYC + 2);
    wr(8'h08); #3; chk("R6 after reset", rx_st, 1);
    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule